// File: doc/BRIEF.md
# Way-Partitioned Victim Selector with Line Locking

This block picks the way to replace in one set of a set-associative cache when a request misses. It holds four state bits per line of that set (valid, dirty, locked, recently-used) and an eviction mask per requester: one for each core and one shared by every non-core hardware agent. Tag comparison happens elsewhere. A hit arrives as a flag plus a way index, and the block updates its line state from it.

One command is accepted per cycle: access, lock, unlock, or mask write. Each command produces a registered response one cycle later. The response carries a way index, a status bit and a writeback flag. The writeback flag tells the surrounding cache that the line being replaced or flushed holds modified data. Partition masks restrict only the choice of victim. Hits may land in any way. Locked lines are never replaced. A lock is refused if it would leave the requester with no unlocked way it may evict from.

Top module: `way_victim_sel`

## Requirements
- R1: Each requester owns a mask with one bit per way. Bit value 0 lets that requester evict from the way, and 1 forbids it. Requester IDs from 0 to NCORE-1 select the core masks. Every ID of NCORE or above selects the single hardware-agent mask. All masks are zero after reset.
- R2: A mask write (op 4) whose value is all ones is rejected with status 1, and the old mask stays in force. Any other value is stored and answered with status 0.
- R3: An access hit (op 1, hit_i high) is allowed in any way, whatever the masks say. It sets that line's used bit, and if wr_i is high it also sets the line's dirty bit. The response returns the hit way with status 0 and no writeback.
- R4: On an access miss, the eligible ways are those that are permitted and unlocked. The victim is chosen in this order: the lowest eligible invalid way; otherwise the lowest eligible way whose used bit is clear; otherwise the used bits of all eligible ways are cleared and the lowest eligible way is chosen. The allocated line becomes valid and used, with dirty equal to wr_i.
- R5: A locked line is never chosen as a victim. If a miss finds no eligible way, the response has status 1 and way 0, and no state changes.
- R6: rsp_wb_o is high for exactly the one response cycle in which the line being replaced or flushed was valid and dirty.
- R7: A lock (op 2) on a hit locks the hit way. A lock on a miss allocates a victim by the R4 rules, with the line clean and locked. The lock fails when no eligible way other than the one being locked would remain; a failed lock returns status 1 and changes nothing. A successful lock, or a lock on a line that is already locked, returns status 0. The way field is the hit way on a hit, the victim on a successful miss, and 0 on a failed miss.
- R8: An unlock (op 3) on a hit clears the line's lock and invalidates the line. Status is 1 if the line was locked and 0 if it was not. An unlock on a miss returns status 0 with way 0 and changes nothing.
- R9: The response is valid exactly one cycle after each non-NOP op. Op encoding: 0 is NOP, 1 access, 2 lock, 3 unlock, 4 mask write. A NOP produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Command code (R9) |
| req_id_i | input | REQ_W | Requester identity |
| hit_i | input | 1 | Request matched a line of this set |
| hit_way_i | input | WAY_W | Way that matched |
| wr_i | input | 1 | Access is a write |
| mask_i | input | WAYS | Mask value for a mask write |
| rsp_valid_o | output | 1 | Response valid |
| rsp_way_o | output | WAY_W | Victim or hit way |
| rsp_wb_o | output | 1 | Replaced or flushed line needs writeback |
| rsp_status_o | output | 1 | Status bit, meaning depends on op |

## Verification
Every result is due exactly one clock after the command that produced it. A command is sampled at the rising edge, and the response register is valid until the next rising edge. The driver applies a command on a falling edge and queues its expected way, status and writeback values. The monitor samples on the following falling edge, in the middle of the response cycle. It pops one entry for each valid response and flags any response that arrives with nothing queued. A final check after idle cycles confirms that no expected response is still missing.

// File: rtl/wvs_pkg.sv
package wvs_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ACCESS  = 3'd1,
        OP_LOCK    = 3'd2,
        OP_UNLOCK  = 3'd3,
        OP_SETMASK = 3'd4
    } wvs_op_e;

    typedef struct packed {
        logic vld;
        logic dty;
        logic lck;
        logic used;
    } wvs_line_t;

endpackage

// File: rtl/wvs_first_one.sv
module wvs_first_one #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end

endmodule

// File: rtl/wvs_mask_bank.sv
module wvs_mask_bank #(
    parameter int WAYS  = 8,
    parameter int NREQ  = 5,
    parameter int IDX_W = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [WAYS-1:0]      wr_mask_i,
    output logic [WAYS-1:0]      rd_mask_o,
    output logic                 reject_o,
    output logic [NREQ*WAYS-1:0] masks_o
);

    logic [NREQ-1:0][WAYS-1:0] mask_d, mask_q;

    assign reject_o  = &wr_mask_i;
    assign rd_mask_o = mask_q[idx_i];
    assign masks_o   = mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_en_i && !reject_o) begin
            mask_d[idx_i] = wr_mask_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
    import wvs_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int NCORE = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int REQ_W = $clog2(NCORE + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [2:0]       op_i,
    input  logic [REQ_W-1:0] req_id_i,
    input  logic             hit_i,
    input  logic [WAY_W-1:0] hit_way_i,
    input  logic             wr_i,
    input  logic [WAYS-1:0]  mask_i,
    output logic             rsp_valid_o,
    output logic [WAY_W-1:0] rsp_way_o,
    output logic             rsp_wb_o,
    output logic             rsp_status_o
);

    localparam int NREQ  = NCORE + 1;
    localparam int NPICK = 3;

    typedef struct packed {
        wvs_line_t [WAYS-1:0] line;
        logic                 rsp_vld;
        logic [WAY_W-1:0]     rsp_way;
        logic                 rsp_wb;
        logic                 rsp_st;
    } state_t;

    state_t s_d, s_q;

    wvs_op_e                op;
    logic [REQ_W-1:0]       req_idx;
    logic [WAYS-1:0]        sel_mask;
    logic                   mask_rej;
    logic                   mask_we;
    logic [NREQ*WAYS-1:0]   all_masks;

    logic [WAYS-1:0] vld_v, dty_v, lock_v, used_v, elig_v;
    logic [WAYS-1:0] hit_bit, vic_bit;
    logic [NPICK-1:0][WAYS-1:0]  cand;
    logic [NPICK-1:0]            found;
    logic [NPICK-1:0][WAY_W-1:0] pos;
    logic [WAY_W-1:0] victim;
    logic             roll;
    logic             spare_hit, spare_miss;
    logic             alloc, alloc_dty, alloc_lck;

    assign op      = wvs_op_e'(op_i);
    assign req_idx = (req_id_i >= REQ_W'(NCORE)) ? REQ_W'(NCORE) : req_id_i;

    wvs_mask_bank #(
        .WAYS  (WAYS),
        .NREQ  (NREQ),
        .IDX_W (REQ_W)
    ) u_masks (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (mask_we),
        .idx_i     (req_idx),
        .wr_mask_i (mask_i),
        .rd_mask_o (sel_mask),
        .reject_o  (mask_rej),
        .masks_o   (all_masks)
    );

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            vld_v[w]  = s_q.line[w].vld;
            dty_v[w]  = s_q.line[w].dty;
            lock_v[w] = s_q.line[w].lck;
            used_v[w] = s_q.line[w].used;
        end
    end

    // Candidate sets in priority order: invalid, not-recently-used, any eligible.
    assign elig_v  = ~sel_mask & ~lock_v;
    assign cand[0] = elig_v & ~vld_v;
    assign cand[1] = elig_v & ~used_v;
    assign cand[2] = elig_v;

    for (genvar g = 0; g < NPICK; g++) begin : g_pick
        wvs_first_one #(
            .N (WAYS),
            .W (WAY_W)
        ) u_pick (
            .vec_i   (cand[g]),
            .found_o (found[g]),
            .idx_o   (pos[g])
        );
    end

    assign victim     = found[0] ? pos[0] : (found[1] ? pos[1] : pos[2]);
    assign roll       = !found[0] && !found[1];
    assign hit_bit    = WAYS'(1) << hit_way_i;
    assign vic_bit    = WAYS'(1) << victim;
    assign spare_hit  = (elig_v & ~hit_bit) != '0;
    assign spare_miss = (elig_v & ~vic_bit) != '0;

    always_comb begin
        s_d         = s_q;
        s_d.rsp_vld = 1'b0;
        s_d.rsp_way = '0;
        s_d.rsp_wb  = 1'b0;
        s_d.rsp_st  = 1'b0;
        mask_we     = 1'b0;
        alloc       = 1'b0;
        alloc_dty   = 1'b0;
        alloc_lck   = 1'b0;

        unique case (op)
            OP_ACCESS: begin
                s_d.rsp_vld = 1'b1;
                if (hit_i) begin
                    s_d.rsp_way                 = hit_way_i;
                    s_d.line[hit_way_i].used    = 1'b1;
                    if (wr_i) s_d.line[hit_way_i].dty = 1'b1;
                end else if (!found[2]) begin
                    s_d.rsp_st = 1'b1;
                end else begin
                    alloc     = 1'b1;
                    alloc_dty = wr_i;
                end
            end
            OP_LOCK: begin
                s_d.rsp_vld = 1'b1;
                if (hit_i) begin
                    s_d.rsp_way = hit_way_i;
                    if (!lock_v[hit_way_i]) begin
                        if (spare_hit) s_d.line[hit_way_i].lck = 1'b1;
                        else           s_d.rsp_st = 1'b1;
                    end
                end else if (found[2] && spare_miss) begin
                    alloc     = 1'b1;
                    alloc_lck = 1'b1;
                end else begin
                    s_d.rsp_st = 1'b1;
                end
            end
            OP_UNLOCK: begin
                s_d.rsp_vld = 1'b1;
                if (hit_i) begin
                    s_d.rsp_way         = hit_way_i;
                    s_d.rsp_st          = lock_v[hit_way_i];
                    s_d.rsp_wb          = vld_v[hit_way_i] & dty_v[hit_way_i];
                    s_d.line[hit_way_i] = '0;
                end
            end
            OP_SETMASK: begin
                s_d.rsp_vld = 1'b1;
                mask_we     = 1'b1;
                s_d.rsp_st  = mask_rej;
            end
            default: ;
        endcase

        if (alloc) begin
            if (roll) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (elig_v[w]) s_d.line[w].used = 1'b0;
                end
            end
            s_d.rsp_way          = victim;
            s_d.rsp_wb           = vld_v[victim] & dty_v[victim];
            s_d.line[victim].vld  = 1'b1;
            s_d.line[victim].dty  = alloc_dty;
            s_d.line[victim].lck  = alloc_lck;
            s_d.line[victim].used = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid_o  = s_q.rsp_vld;
    assign rsp_way_o    = s_q.rsp_way;
    assign rsp_wb_o     = s_q.rsp_wb;
    assign rsp_status_o = s_q.rsp_st;

endmodule

// File: rtl/wvs_checker.sv
module wvs_checker
    import wvs_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int NREQ  = 5,
    parameter int WAY_W = 3
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [2:0]           op_i,
    input logic                 hit_i,
    input logic                 rsp_valid_o,
    input logic [WAY_W-1:0]     rsp_way_o,
    input logic                 rsp_wb_o,
    input logic                 rsp_status_o,
    input logic [WAYS-1:0]      lock_vec_i,
    input logic [WAYS-1:0]      sel_mask_i,
    input logic [NREQ*WAYS-1:0] masks_i
);

    logic [WAYS-1:0] lock_prev_q, mask_prev_q;
    logic            miss_alloc_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lock_prev_q  <= '0;
            mask_prev_q  <= '0;
            miss_alloc_q <= 1'b0;
        end else begin
            lock_prev_q  <= lock_vec_i;
            mask_prev_q  <= sel_mask_i;
            miss_alloc_q <= ((op_i == 3'(OP_ACCESS)) || (op_i == 3'(OP_LOCK))) && !hit_i;
        end
    end

    a_r6_wb_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_wb_o |-> rsp_valid_o);

    a_r9_rsp_after_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> $past(op_i) != 3'(OP_NOP));

    a_r5_victim_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miss_alloc_q && rsp_valid_o && !rsp_status_o) |-> !lock_prev_q[rsp_way_o]);

    a_r1_victim_permitted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miss_alloc_q && rsp_valid_o && !rsp_status_o) |-> !mask_prev_q[rsp_way_o]);

    for (genvar r = 0; r < NREQ; r++) begin : g_mask_chk
        a_r2_mask_never_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(&masks_i[r*WAYS +: WAYS]));
    end

endmodule

bind way_victim_sel wvs_checker #(
    .WAYS  (WAYS),
    .NREQ  (NCORE + 1),
    .WAY_W (WAY_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op_i),
    .hit_i        (hit_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_way_o    (rsp_way_o),
    .rsp_wb_o     (rsp_wb_o),
    .rsp_status_o (rsp_status_o),
    .lock_vec_i   (lock_v),
    .sel_mask_i   (sel_mask),
    .masks_i      (all_masks)
);

// File: tb/way_victim_sel_bench.sv
`timescale 1ns/1ps
module way_victim_sel_bench;

    localparam int WAYS  = 4;
    localparam int NCORE = 2;
    localparam int WAY_W = 2;
    localparam int REQ_W = 2;

    localparam logic [2:0] NOP = 3'd0, ACC = 3'd1, LCK = 3'd2, ULK = 3'd3, MSK = 3'd4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       op = NOP;
    logic [REQ_W-1:0] req_id = '0;
    logic             hit = 1'b0;
    logic [WAY_W-1:0] hit_way = '0;
    logic             wr = 1'b0;
    logic [WAYS-1:0]  mask = '0;
    logic             rsp_valid;
    logic [WAY_W-1:0] rsp_way;
    logic             rsp_wb;
    logic             rsp_status;

    always #2 clk = ~clk;

    way_victim_sel #(.WAYS(WAYS), .NCORE(NCORE)) u_way_victim_sel (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .op_i         (op),
        .req_id_i     (req_id),
        .hit_i        (hit),
        .hit_way_i    (hit_way),
        .wr_i         (wr),
        .mask_i       (mask),
        .rsp_valid_o  (rsp_valid),
        .rsp_way_o    (rsp_way),
        .rsp_wb_o     (rsp_wb),
        .rsp_status_o (rsp_status)
    );

    typedef struct {
        int    way;
        bit    wb;
        bit    st;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic drive(input logic [2:0] o, input int id, input bit h, input int hw,
                         input bit w, input logic [WAYS-1:0] m,
                         input int ew, input bit ewb, input bit est, input string tag);
        exp_t e;
        e.way = ew; e.wb = ewb; e.st = est; e.tag = tag;
        exp_q.push_back(e);
        op      = o;
        req_id  = REQ_W'(id);
        hit     = h;
        hit_way = WAY_W'(hw);
        wr      = w;
        mask    = m;
        @(negedge clk);
        op      = NOP;
    endtask

    // Monitor: the response register is valid in the cycle after the command edge.
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected response: actual way=%0d wb=%0b st=%0b expected none",
                         rsp_way, rsp_wb, rsp_status);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (int'(rsp_way) != e.way || rsp_wb != e.wb || rsp_status != e.st) begin
                    n_fail++;
                    $display("FAIL %s: actual way=%0d wb=%0b st=%0b expected way=%0d wb=%0b st=%0b",
                             e.tag, rsp_way, rsp_wb, rsp_status, e.way, e.wb, e.st);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rsp_valid || rsp_wb || rsp_status) begin
            n_fail++;
            $display("FAIL R9 reset state: actual vld=%0b wb=%0b st=%0b expected 0 0 0",
                     rsp_valid, rsp_wb, rsp_status);
        end

        // Fill the set: invalid ways first (R4)
        drive(ACC, 0, 0, 0, 1, '0, 0, 0, 0, "R4 fill way0");
        drive(ACC, 0, 0, 0, 0, '0, 1, 0, 0, "R4 fill way1");
        drive(ACC, 1, 0, 0, 1, '0, 2, 0, 0, "R4 fill way2");
        drive(ACC, 1, 0, 0, 0, '0, 3, 0, 0, "R4 fill way3");
        // All used: roll over, dirty way0 written back (R4, R6)
        drive(ACC, 0, 0, 0, 0, '0, 0, 1, 0, "R4 R6 rollover dirty way0");
        drive(ACC, 0, 0, 0, 0, '0, 1, 0, 0, "R4 lowest unused way1");
        // Rejected all-ones mask, old mask kept (R2)
        drive(MSK, 1, 0, 0, 0, 4'b1111, 0, 0, 1, "R2 reject full mask");
        drive(ACC, 1, 0, 0, 0, '0, 2, 1, 0, "R2 old mask kept, dirty way2");
        drive(MSK, 1, 0, 0, 0, 4'b0011, 0, 0, 0, "R2 accept mask");
        drive(ACC, 1, 0, 0, 1, '0, 3, 0, 0, "R1 masked victim way3");
        // Hit in a way the requester may not evict (R3)
        drive(ACC, 1, 1, 0, 1, '0, 0, 0, 0, "R3 hit outside mask");
        drive(ACC, 1, 0, 0, 0, '0, 2, 0, 0, "R1 rollover only ways 2,3");
        // Locking (R7)
        drive(LCK, 1, 1, 3, 0, '0, 3, 0, 0, "R7 lock hit ok");
        drive(LCK, 1, 1, 2, 0, '0, 2, 0, 1, "R7 lock last way refused");
        drive(ACC, 1, 0, 0, 0, '0, 2, 0, 0, "R5 locked way3 skipped");
        // Hardware agent (id 2 -> shared mask, all zero)
        drive(ACC, 2, 0, 0, 0, '0, 0, 1, 0, "R1 hw mask rollover dirty way0");
        // Unlock (R8)
        drive(ULK, 0, 1, 3, 0, '0, 3, 1, 1, "R8 unlock locked dirty");
        drive(ULK, 0, 1, 1, 0, '0, 1, 0, 0, "R8 flush unlocked clean");
        drive(ULK, 0, 0, 0, 0, '0, 0, 0, 0, "R8 unlock miss");
        drive(ACC, 0, 0, 0, 0, '0, 1, 0, 0, "R8 flushed way1 invalid");
        drive(ACC, 1, 0, 0, 0, '0, 3, 0, 0, "R8 unlocked way3 invalid");
        drive(ACC, 0, 1, 2, 1, '0, 2, 0, 0, "R3 write hit sets dirty");
        drive(ULK, 0, 1, 2, 0, '0, 2, 1, 0, "R8 R6 flush dirty unlocked");
        // Lock on miss (R7)
        drive(LCK, 1, 0, 0, 0, '0, 2, 0, 0, "R7 lock miss allocates way2");
        drive(LCK, 1, 0, 0, 0, '0, 0, 0, 1, "R7 lock miss refused");
        drive(ACC, 1, 0, 0, 0, '0, 3, 0, 0, "R7 refused lock changed nothing");
        // No eligible way (R5)
        drive(MSK, 0, 0, 0, 0, 4'b1100, 0, 0, 0, "R2 core0 mask");
        drive(LCK, 0, 1, 0, 0, '0, 0, 0, 0, "R7 lock way0");
        drive(LCK, 0, 1, 3, 0, '0, 3, 0, 0, "R7 lock way3 outside mask");
        drive(ACC, 1, 0, 0, 0, '0, 0, 0, 1, "R5 no eligible way");

        repeat (4) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule